// File: doc/BRIEF.md
# Private System Region Access Decoder

This block sits on the processor's private peripheral path. It takes one bus request, made of an address, an access size, a read/write flag and the secure and privileged attributes. In the same cycle it picks the target that will serve the request. The possible targets are the system-register/interrupt-controller block and the two banks of the tick timer. Requests that no target claims are completed locally: an unprivileged access gets a bus error, and a privileged one reads as zero with its write dropped.

Where regions overlap, the tick-timer window wins over the system-register page, and the system-register page wins over the default handler. A non-secure view of the system-register page sits at a second address. Secure requests there are forwarded to the same targets as in the main page, with the secure attribute cleared. Non-secure requests there are completed locally. The parameter `ALIAS_EN` builds both the alias and the secure timer bank. When it is 0, alias addresses behave like any other unclaimed address, and every timer access goes to the non-secure bank.

Top module: `ppb_sec_decoder`

## Requirements
- R1: Addresses outside 0xE0000000..0xE00FFFFF give hit_o=0, tgt_o=0, raz_o=0, err_o=0 and all forwarded outputs 0.
- R2: A privileged access to an unclaimed address in the region with size_i<=3 gives raz_o=1, err_o=0 and tgt_o=0. It also gives rdata_o=0, and fwd_wr_o=0 for writes.
- R3: An unprivileged access to an unclaimed address in the region gives err_o=1 and raz_o=0.
- R4: In an unclaimed address, a size code size_i above 3 (more than 8 bytes; the size is 2**size_i) gives err_o=1, even for privileged accesses.
- R5: Addresses 0xE000E000..0xE000EFFF outside the timer window select the system target tgt_o=3'b001. fwd_secure_o, fwd_priv_o and fwd_wr_o equal the inputs, and fwd_off_o carries address bits 11:0.
- R6: Addresses 0xE000E010..0xE000E0EF select the timer, not the system target. A secure access selects the secure bank (3'b100) and a non-secure one selects the non-secure bank (3'b010).
- R7: With ALIAS_EN=1, a secure access to 0xE002E000..0xE002EFFF is routed as at the same offset of the main page with a non-secure attribute. The timer sub-window goes to 3'b010 and the rest to 3'b001, with fwd_secure_o=0 and the privilege passed through.
- R8: With ALIAS_EN=1, a non-secure access to the alias page gives raz_o=1 if privileged and err_o=1 if not, regardless of size_i.
- R9: At most one of tgt_o bits, raz_o and err_o is set at any time.
- R10: With ALIAS_EN=0, alias addresses follow R2..R4, and a secure access to the main timer window selects 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| addr_i | input | ADDR_W | Request address |
| size_i | input | 3 | Access size code, bytes = 2**size_i |
| wr_i | input | 1 | 1 = write |
| secure_i | input | 1 | Secure attribute |
| priv_i | input | 1 | Privileged attribute |
| hit_o | output | 1 | Address lies in the private region |
| tgt_o | output | 3 | One-hot target: bit0 system, bit1 timer non-secure, bit2 timer secure |
| raz_o | output | 1 | Completed locally, read as zero, write ignored |
| err_o | output | 1 | Bus error response |
| rdata_o | output | DATA_W | Read data for local completion |
| fwd_secure_o | output | 1 | Secure attribute forwarded to target |
| fwd_priv_o | output | 1 | Privileged attribute forwarded to target |
| fwd_wr_o | output | 1 | Write flag forwarded to target |
| fwd_off_o | output | OFF_W | Offset within the system page |

## Verification
Every result is purely combinational, so each output is due in the same cycle as the request that caused it. The bench drives a request on a falling clock edge and samples all outputs a quarter period later. That is well before the next rising edge, where the embedded properties sample. Two instances share the stimulus, one with the alias built and one without. This lets R7, R8 and R10 be compared against each other on identical addresses.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam int TGT_N = 3;
  localparam int SEL_SYS     = 0;
  localparam int SEL_TICK_NS = 1;
  localparam int SEL_TICK_S  = 2;
  localparam logic [2:0] MAX_SIZE_CODE = 3'd3;
endpackage

// File: rtl/ppb_window.sv
module ppb_window #(
  parameter int          ADDR_W = 32,
  parameter logic [63:0] BASE   = 64'hE000_0000,
  parameter logic [63:0] SIZE   = 64'h1000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W:0] LO = BASE[ADDR_W:0];
  localparam logic [ADDR_W:0] HI = BASE[ADDR_W:0] + SIZE[ADDR_W:0];

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr_i};
  assign hit_o  = (addr_x >= LO) && (addr_x < HI);
endmodule

// File: rtl/ppb_route.sv
module ppb_route
  import ppb_pkg::*;
#(
  parameter bit ALIAS_EN = 1'b1
) (
  input  logic             in_ppb_i,
  input  logic             in_scs_i,
  input  logic             in_tick_i,
  input  logic             in_alias_i,
  input  logic             in_alias_tick_i,
  input  logic             secure_i,
  input  logic             priv_i,
  input  logic [2:0]       size_i,
  output logic [TGT_N-1:0] tgt_o,
  output logic             raz_o,
  output logic             err_o,
  output logic             sec_o
);
  logic size_ok;
  assign size_ok = (size_i <= MAX_SIZE_CODE);

  always_comb begin
    tgt_o = '0;
    raz_o = 1'b0;
    err_o = 1'b0;
    sec_o = secure_i;
    if (!in_ppb_i) begin
      sec_o = 1'b0;
    end else if (in_tick_i) begin
      // highest priority: timer window, bank picked by attribute
      if (secure_i && ALIAS_EN) tgt_o[SEL_TICK_S] = 1'b1;
      else                      tgt_o[SEL_TICK_NS] = 1'b1;
    end else if (in_scs_i) begin
      tgt_o[SEL_SYS] = 1'b1;
    end else if (ALIAS_EN && in_alias_i) begin
      if (secure_i) begin
        sec_o = 1'b0;
        if (in_alias_tick_i) tgt_o[SEL_TICK_NS] = 1'b1;
        else                 tgt_o[SEL_SYS] = 1'b1;
      end else if (priv_i) begin
        raz_o = 1'b1;
      end else begin
        err_o = 1'b1;
      end
    end else if (!priv_i || !size_ok) begin
      err_o = 1'b1;
    end else begin
      raz_o = 1'b1;
    end
  end
endmodule

// File: rtl/ppb_sec_decoder.sv
module ppb_sec_decoder
  import ppb_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 64,
  parameter bit          ALIAS_EN   = 1'b1,
  parameter logic [63:0] PPB_BASE   = 64'hE000_0000,
  parameter logic [63:0] PPB_SIZE   = 64'h0010_0000,
  parameter logic [63:0] SCS_BASE   = 64'hE000_E000,
  parameter logic [63:0] ALIAS_BASE = 64'hE002_E000,
  parameter logic [63:0] PAGE_SIZE  = 64'h1000,
  parameter logic [63:0] TICK_OFF   = 64'h010,
  parameter logic [63:0] TICK_SIZE  = 64'h0E0,
  localparam int         OFF_W      = $clog2(PAGE_SIZE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic              wr_i,
  input  logic              secure_i,
  input  logic              priv_i,
  output logic              hit_o,
  output logic [TGT_N-1:0]  tgt_o,
  output logic              raz_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fwd_secure_o,
  output logic              fwd_priv_o,
  output logic              fwd_wr_o,
  output logic [OFF_W-1:0]  fwd_off_o
);
  logic in_ppb, in_scs, in_tick, in_alias, in_alias_tick;
  logic sec_int, any_tgt;

  ppb_window #(.ADDR_W(ADDR_W), .BASE(PPB_BASE), .SIZE(PPB_SIZE))
    u_win_ppb (.addr_i(addr_i), .hit_o(in_ppb));
  ppb_window #(.ADDR_W(ADDR_W), .BASE(SCS_BASE), .SIZE(PAGE_SIZE))
    u_win_scs (.addr_i(addr_i), .hit_o(in_scs));
  ppb_window #(.ADDR_W(ADDR_W), .BASE(SCS_BASE + TICK_OFF), .SIZE(TICK_SIZE))
    u_win_tick (.addr_i(addr_i), .hit_o(in_tick));

  generate
    if (ALIAS_EN) begin : g_alias
      ppb_window #(.ADDR_W(ADDR_W), .BASE(ALIAS_BASE), .SIZE(PAGE_SIZE))
        u_win_alias (.addr_i(addr_i), .hit_o(in_alias));
      ppb_window #(.ADDR_W(ADDR_W), .BASE(ALIAS_BASE + TICK_OFF), .SIZE(TICK_SIZE))
        u_win_alias_tick (.addr_i(addr_i), .hit_o(in_alias_tick));
    end else begin : g_no_alias
      assign in_alias      = 1'b0;
      assign in_alias_tick = 1'b0;
    end
  endgenerate

  ppb_route #(.ALIAS_EN(ALIAS_EN)) u_route (
    .in_ppb_i       (in_ppb),
    .in_scs_i       (in_scs),
    .in_tick_i      (in_tick),
    .in_alias_i     (in_alias),
    .in_alias_tick_i(in_alias_tick),
    .secure_i       (secure_i),
    .priv_i         (priv_i),
    .size_i         (size_i),
    .tgt_o          (tgt_o),
    .raz_o          (raz_o),
    .err_o          (err_o),
    .sec_o          (sec_int)
  );

  assign any_tgt      = |tgt_o;
  assign hit_o        = in_ppb;
  assign rdata_o      = '0;
  assign fwd_secure_o = any_tgt & sec_int;
  assign fwd_priv_o   = any_tgt & priv_i;
  assign fwd_wr_o     = any_tgt & wr_i;
  assign fwd_off_o    = any_tgt ? addr_i[OFF_W-1:0] : '0;

  AST_RESP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tgt_o, raz_o, err_o})) else $error("one-hot response"); // R9
  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (tgt_o == '0) && !raz_o && !err_o) else $error("outside quiet"); // R1
  AST_TICK_OVER_SYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tick |-> !tgt_o[SEL_SYS] && any_tgt) else $error("tick priority"); // R6
  AST_ALIAS_CLEARS_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_alias && !in_scs && secure_i) |-> !fwd_secure_o && any_tgt) else $error("alias sec"); // R7
  AST_USER_NO_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_i |-> !raz_o) else $error("user raz"); // R3
  AST_LOCAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raz_o || err_o) |-> !fwd_wr_o) else $error("write leak"); // R2
endmodule

// File: tb/sim_ppb_sec_decoder.sv
module sim_ppb_sec_decoder;
  localparam int PERIOD = 10;
  localparam int NRAND  = 1500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  size = '0;
  logic wr = 1'b0, sec = 1'b0, pr = 1'b0;

  logic        hit0, raz0, err0, fs0, fp0, fw0, hit1, raz1, err1, fs1, fp1, fw1;
  logic [2:0]  tgt0, tgt1;
  logic [63:0] rd0, rd1;
  logic [11:0] off0, off1;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  ppb_sec_decoder #(.ALIAS_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size), .wr_i(wr),
    .secure_i(sec), .priv_i(pr), .hit_o(hit0), .tgt_o(tgt0), .raz_o(raz0),
    .err_o(err0), .rdata_o(rd0), .fwd_secure_o(fs0), .fwd_priv_o(fp0),
    .fwd_wr_o(fw0), .fwd_off_o(off0));
  ppb_sec_decoder #(.ALIAS_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size), .wr_i(wr),
    .secure_i(sec), .priv_i(pr), .hit_o(hit1), .tgt_o(tgt1), .raz_o(raz1),
    .err_o(err1), .rdata_o(rd1), .fwd_secure_o(fs1), .fwd_priv_o(fp1),
    .fwd_wr_o(fw1), .fwd_off_o(off1));

  function automatic bit inr(logic [31:0] a, logic [31:0] lo, logic [31:0] n);
    return ({1'b0, a} >= {1'b0, lo}) && ({1'b0, a} < {1'b0, lo} + {1'b0, n});
  endfunction

  // {hit, tgt[2:0], raz, err, fsec, fpriv, fwr, off[11:0]}
  function automatic logic [20:0] model(logic [31:0] a, logic [2:0] sz, bit w,
                                        bit s, bit p, bit aen);
    logic [2:0] t = 3'b000;
    bit r = 0, e = 0, fs = s;
    if (!inr(a, 32'hE000_0000, 32'h0010_0000)) return '0;           // R1
    if (inr(a, 32'hE000_E010, 32'h0E0))      t = (s && aen) ? 3'b100 : 3'b010; // R6 R10
    else if (inr(a, 32'hE000_E000, 32'h1000)) t = 3'b001;           // R5
    else if (aen && inr(a, 32'hE002_E000, 32'h1000)) begin
      if (s) begin                                                   // R7
        fs = 0;
        t = inr(a, 32'hE002_E010, 32'h0E0) ? 3'b010 : 3'b001;
      end else if (p) r = 1; else e = 1;                             // R8
    end else if (!p || sz > 3) e = 1;                                // R3 R4
    else r = 1;                                                      // R2
    if (t == 0) return {1'b1, 3'b000, r, e, 3'b000, 12'h0};
    return {1'b1, t, 1'b0, 1'b0, fs, p, w, a[11:0]};
  endfunction

  function automatic string tag(logic [31:0] a, logic [2:0] sz, bit s, bit p, bit aen);
    if (!inr(a, 32'hE000_0000, 32'h0010_0000)) return "R1";
    if (inr(a, 32'hE000_E010, 32'h0E0)) return aen ? "R6" : "R10";
    if (inr(a, 32'hE000_E000, 32'h1000)) return "R5";
    if (inr(a, 32'hE002_E000, 32'h1000)) begin
      if (!aen) return "R10";
      return s ? "R7" : "R8";
    end
    if (!p) return "R3";
    if (sz > 3) return "R4";
    return "R2";
  endfunction

  task automatic cmp(string req, logic [20:0] act, logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h size=%0d wr=%0b sec=%0b priv=%0b actual=%h expected=%h",
               req, addr, size, wr, sec, pr, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [2:0] sz, bit w, bit s, bit p);
    @(negedge clk);
    addr = a; size = sz; wr = w; sec = s; pr = p;
    #(PERIOD/4);
    cmp(tag(a, sz, s, p, 1'b1), {hit0, tgt0, raz0, err0, fs0, fp0, fw0, off0},
        model(a, sz, w, s, p, 1'b1));
    cmp(tag(a, sz, s, p, 1'b0), {hit1, tgt1, raz1, err1, fs1, fp1, fw1, off1},
        model(a, sz, w, s, p, 1'b0));
    checks++;
    if (raz0 && rd0 !== 64'h0) begin
      errors++;
      $display("FAIL R2 rdata actual=%h expected=0", rd0);
    end
    checks++;
    if (($countones({tgt0, raz0, err0}) > 1) || ($countones({tgt1, raz1, err1}) > 1)) begin
      errors++;
      $display("FAIL R9 actual=%b/%b expected at most one bit", {tgt0, raz0, err0}, {tgt1, raz1, err1});
    end
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] edges [9] = '{32'hE000_E00F, 32'hE000_E0F0, 32'hE000_E0EF,
                               32'hE00F_FFFF, 32'hE010_0000, 32'hDFFF_FFFF,
                               32'hE002_DFFF, 32'hE002_F000, 32'hE002_E0F0};
    case ($urandom_range(6))
      0: return $urandom() & 32'h7FFF_FFFF;
      1: return 32'hE000_0000 + $urandom_range(32'h000F_FFFF);
      2: return 32'hE000_E000 + $urandom_range(32'hFFF);
      3: return 32'hE000_E010 + $urandom_range(32'hDF);
      4: return 32'hE002_E000 + $urandom_range(32'hFFF);
      5: return 32'hE002_E010 + $urandom_range(32'hDF);
      default: return edges[$urandom_range(8)];
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    #(PERIOD/4);
    // reset state with idle inputs: address 0 is outside the region, R1
    cmp("R1", {hit0, tgt0, raz0, err0, fs0, fp0, fw0, off0}, 21'h0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(32'h0000_1234, 3'd2, 1, 1, 1);   // R1
    apply(32'hE010_0000, 3'd0, 0, 1, 1);   // R1 upper edge
    apply(32'hE000_1000, 3'd3, 1, 0, 1);   // R2 write ignored
    apply(32'hE000_1000, 3'd2, 0, 0, 0);   // R3
    apply(32'hE00F_FFFF, 3'd4, 0, 1, 1);   // R4
    apply(32'hE000_E004, 3'd2, 1, 1, 0);   // R5
    apply(32'hE000_E00F, 3'd0, 0, 0, 1);   // R5 below timer
    apply(32'hE000_E010, 3'd2, 1, 1, 1);   // R6 secure bank
    apply(32'hE000_E0EF, 3'd0, 0, 0, 1);   // R6 nonsecure bank
    apply(32'hE000_E0F0, 3'd2, 0, 1, 1);   // R5 above timer
    apply(32'hE002_E018, 3'd2, 1, 1, 1);   // R7 alias timer
    apply(32'hE002_ED00, 3'd2, 0, 1, 0);   // R7 alias sys
    apply(32'hE002_ED00, 3'd2, 1, 0, 1);   // R8 raz
    apply(32'hE002_E010, 3'd7, 0, 0, 0);   // R8 fault
    apply(32'hE002_E010, 3'd7, 0, 0, 1);   // R8 size ignored, R10 size fault
    for (int i = 0; i < NRAND; i++)
      apply(pick_addr(), 3'($urandom_range(7)), 1'($urandom), 1'($urandom), 1'($urandom));
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule